// File: doc/BRIEF.md
# ADC Result Buffer Register Window

This block sits between a host register bus and a multi-channel ADC conversion controller. The controller deposits signed 14-bit conversion results into a small buffer through its own write port. The host sees the block through one 16-bit data window. Two mode inputs decide what an access to that window means:

- **Buffer mode:** a host read returns the buffer entry chosen by a 5-bit buffer pointer. The result is formatted right aligned (sign extended) or left aligned (shifted up, low bits zero).
- **Averaging mode:** a host write goes to one of four averaging-configuration registers, chosen by a 2-bit pointer. Each register holds a sample-count code for the averaging logic downstream. These codes are brought out on a packed output.
- **Configuration mode:** the window is inert.

Each pointer steps forward by itself after the access it serves. A block of results can therefore be drained, or all four averaging registers programmed, without reloading the pointer. Averaging registers are write-protected while a conversion is running. A blocked write also leaves the pointer where it was.

Top module: `adc_result_port`

## Requirements
- R1: After reset every buffer entry, every averaging register, both pointers and `hostRdData` are zero, so `avgSel` reads 0.
- R2: With `cfgMode`=0, `avgMode`=0 and `alignLeft`=0, a cycle with `hostRd`=1 loads `hostRdData` at the next clock edge. The value is the buffer entry at the buffer pointer, sign extended from 14 to 16 bits, so bits 15:13 all equal the entry's bit 13.
- R3: With `alignLeft`=1 the same read returns the 14-bit entry in bits 15:2, with bits 1:0 zero.
- R4: Each buffer-mode read advances the buffer pointer by one, and it wraps from 24 to 0.
- R5: A controller write (`ctrlWrValid`=1) stores `ctrlWrData` at `ctrlWrAddr` when the address is 0..24. An address of 25..31 changes no entry. A host write in buffer mode changes no entry.
- R6: When a controller write and a buffer-mode host read hit the same entry in the same cycle, the read returns the old value. A later read returns the new one.
- R7: With `cfgMode`=0, `avgMode`=1 and `convBusy`=0, a host write stores `hostWrData[1:0]` into averaging register k, where k is the averaging pointer. The pointer then advances and wraps from 3 to 0. Register k appears on `avgSel[2k+1:2k]`. Code 00 means 1 sample, 01 means 4, 10 means 8 and 11 means 16.
- R8: A host write in averaging mode while `convBusy`=1 changes no averaging register and leaves the averaging pointer unchanged.
- R9: A host read in averaging mode returns the averaging register at the averaging pointer in bits 1:0, with bits 15:2 zero. It does not move either pointer.
- R10: `idxSet` with a value of 0..24 loads the buffer pointer with the value and the averaging pointer with its bits 1:0. A value of 25..31 is ignored. A load takes priority over a same-cycle pointer step.
- R11: With `cfgMode`=1, a host read returns 0, a host write changes nothing, and neither pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 1 | Configuration mode; the window is inert when set |
| avgMode | input | 1 | Selects averaging registers instead of the buffer |
| alignLeft | input | 1 | Left-aligned result format when set |
| convBusy | input | 1 | Conversion in progress; blocks averaging writes |
| idxSet | input | 1 | Load both pointers |
| idxSetValue | input | 5 | Pointer load value |
| hostRd | input | 1 | Host read strobe of the data window |
| hostWr | input | 1 | Host write strobe of the data window |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Registered read data, valid the cycle after `hostRd` |
| ctrlWrValid | input | 1 | Controller result write strobe |
| ctrlWrAddr | input | 5 | Controller result entry address |
| ctrlWrData | input | 14 | Controller result, two's complement |
| avgSel | output | 8 | Packed averaging codes, register k at bits 2k+1:2k |

## Verification
The hardest case to reach from the ports is a controller write and a host read landing on the same entry in the same cycle. The bench first loads the pointer to that entry. It then raises both strobes on one falling edge, so both are sampled at the same rising edge. It checks that the old value comes back, then reloads the pointer and reads again to see the new value. The blocked averaging write is shown to keep its pointer by a second, unblocked write: that write must land in the register the blocked one would have hit.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic rdBuf;
    logic rdAvg;
    logic rdNone;
    logic wrAvg;
  } win_strobe_t;
endpackage

// File: rtl/adc_win_ctrl.sv
module adc_win_ctrl
  import adc_win_pkg::*;
#(
  parameter int DEPTH  = 25,
  parameter int IDX_W  = 5,
  parameter int AVG_N  = 4,
  parameter int AIDX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMode,
  input  logic              avgMode,
  input  logic              convBusy,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              idxSet,
  input  logic [IDX_W-1:0]  idxSetValue,
  output win_strobe_t       strobe,
  output logic [IDX_W-1:0]  bufIdx,
  output logic [AIDX_W-1:0] avgIdx
);
  localparam logic [IDX_W-1:0]  BUF_LAST = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0]  BUF_SIZE = IDX_W'(DEPTH);
  localparam logic [AIDX_W-1:0] AVG_LAST = AIDX_W'(AVG_N - 1);

  logic bufWin;
  logic avgWin;
  logic loadOk;

  always_comb begin
    bufWin        = !cfgMode && !avgMode;
    avgWin        = !cfgMode && avgMode;
    strobe.rdBuf  = hostRd && bufWin;
    strobe.rdAvg  = hostRd && avgWin;
    strobe.rdNone = hostRd && cfgMode;
    strobe.wrAvg  = hostWr && avgWin && !convBusy;
    loadOk        = idxSet && (idxSetValue < BUF_SIZE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufIdx <= '0;
    end else if (loadOk) begin
      bufIdx <= idxSetValue;
    end else if (strobe.rdBuf) begin
      bufIdx <= (bufIdx == BUF_LAST) ? '0 : bufIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      avgIdx <= '0;
    end else if (loadOk) begin
      avgIdx <= idxSetValue[AIDX_W-1:0];
    end else if (strobe.wrAvg) begin
      avgIdx <= (avgIdx == AVG_LAST) ? '0 : avgIdx + 1'b1;
    end
  end

  // R4: pointer stays inside the buffer and wraps after the last entry
  assert_buf_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    bufIdx < BUF_SIZE);
  assert_buf_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdBuf && !idxSet && bufIdx == BUF_LAST) |=> (bufIdx == '0));

  // R8: blocked averaging write keeps the averaging pointer
  assert_blocked_keeps_idx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && avgMode && !cfgMode && convBusy && !idxSet) |=> $stable(avgIdx));

  // R11: configuration mode never moves a pointer
  assert_cfg_no_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && !idxSet) |=> ($stable(bufIdx) && $stable(avgIdx)));

  // R10: out-of-range load is ignored
  assert_bad_load_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (idxSet && idxSetValue >= BUF_SIZE && !hostRd && !hostWr) |=> ($stable(bufIdx) && $stable(avgIdx)));
endmodule

// File: rtl/adc_win_data.sv
module adc_win_data
  import adc_win_pkg::*;
#(
  parameter int DEPTH  = 25,
  parameter int DATA_W = 14,
  parameter int REG_W  = 16,
  parameter int IDX_W  = 5,
  parameter int AVG_N  = 4,
  parameter int AIDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  win_strobe_t            strobe,
  input  logic [IDX_W-1:0]       bufIdx,
  input  logic [AIDX_W-1:0]      avgIdx,
  input  logic                   alignLeft,
  input  logic [REG_W-1:0]       hostWrData,
  input  logic                   ctrlWrValid,
  input  logic [IDX_W-1:0]       ctrlWrAddr,
  input  logic [DATA_W-1:0]      ctrlWrData,
  output logic [REG_W-1:0]       hostRdData,
  output logic [AVG_N*SEL_W-1:0] avgSel
);
  localparam int PAD = REG_W - DATA_W;

  logic [DATA_W-1:0] resultMem [DEPTH];
  logic [SEL_W-1:0]  avgReg [AVG_N];
  logic [DATA_W-1:0] bufWord;
  logic [REG_W-1:0]  bufFmt;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resultMem[e] <= '0;
      end else if (ctrlWrValid && ctrlWrAddr == IDX_W'(e)) begin
        resultMem[e] <= ctrlWrData;
      end
    end
  end

  for (genvar k = 0; k < AVG_N; k++) begin : g_avg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        avgReg[k] <= '0;
      end else if (strobe.wrAvg && avgIdx == AIDX_W'(k)) begin
        avgReg[k] <= hostWrData[SEL_W-1:0];
      end
    end
    assign avgSel[k*SEL_W +: SEL_W] = avgReg[k];
  end

  always_comb begin
    bufWord = resultMem[bufIdx];
    if (alignLeft) begin
      bufFmt = {bufWord, {PAD{1'b0}}};
    end else begin
      bufFmt = {{PAD{bufWord[DATA_W-1]}}, bufWord};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
    end else if (strobe.rdBuf) begin
      hostRdData <= bufFmt;
    end else if (strobe.rdAvg) begin
      hostRdData <= {{(REG_W-SEL_W){1'b0}}, avgReg[avgIdx]};
    end else if (strobe.rdNone) begin
      hostRdData <= '0;
    end
  end

  // R3: left-aligned reads leave the low pad bits at zero
  assert_left_pad_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdBuf && alignLeft) |=> (hostRdData[PAD-1:0] == '0));

  // R9: averaging reads carry zero in the reserved bits
  assert_avg_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAvg |=> (hostRdData[REG_W-1:SEL_W] == '0));

  // R8: averaging codes move only on an accepted write
  assert_avg_only_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrAvg |=> $stable(avgSel));

  // R2: read data holds between reads
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdBuf || strobe.rdAvg || strobe.rdNone) |=> $stable(hostRdData));
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_win_pkg::*;
#(
  parameter int DEPTH  = 25,
  parameter int DATA_W = 14,
  parameter int REG_W  = 16,
  parameter int AVG_N  = 4,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int AIDX_W = $clog2(AVG_N)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgMode,
  input  logic                   avgMode,
  input  logic                   alignLeft,
  input  logic                   convBusy,
  input  logic                   idxSet,
  input  logic [IDX_W-1:0]       idxSetValue,
  input  logic                   hostRd,
  input  logic                   hostWr,
  input  logic [REG_W-1:0]       hostWrData,
  output logic [REG_W-1:0]       hostRdData,
  input  logic                   ctrlWrValid,
  input  logic [IDX_W-1:0]       ctrlWrAddr,
  input  logic [DATA_W-1:0]      ctrlWrData,
  output logic [AVG_N*SEL_W-1:0] avgSel
);
  win_strobe_t       strobe;
  logic [IDX_W-1:0]  bufIdx;
  logic [AIDX_W-1:0] avgIdx;

  adc_win_ctrl #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .AVG_N(AVG_N), .AIDX_W(AIDX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .avgMode(avgMode),
    .convBusy(convBusy), .hostRd(hostRd), .hostWr(hostWr),
    .idxSet(idxSet), .idxSetValue(idxSetValue),
    .strobe(strobe), .bufIdx(bufIdx), .avgIdx(avgIdx)
  );

  adc_win_data #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .IDX_W(IDX_W),
    .AVG_N(AVG_N), .AIDX_W(AIDX_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bufIdx(bufIdx),
    .avgIdx(avgIdx), .alignLeft(alignLeft), .hostWrData(hostWrData),
    .ctrlWrValid(ctrlWrValid), .ctrlWrAddr(ctrlWrAddr),
    .ctrlWrData(ctrlWrData), .hostRdData(hostRdData), .avgSel(avgSel)
  );
endmodule

// File: tb/adc_result_port_tb.sv
module adc_result_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgMode, avgMode, alignLeft, convBusy;
  logic        idxSet;
  logic [4:0]  idxSetValue;
  logic        hostRd, hostWr;
  logic [15:0] hostWrData, hostRdData;
  logic        ctrlWrValid;
  logic [4:0]  ctrlWrAddr;
  logic [13:0] ctrlWrData;
  logic [7:0]  avgSel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [13:0] mdlMem [25];
  logic [1:0]  mdlAvg [4];
  int          mdlBuf;
  int          mdlAvgIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_port dut_i (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .avgMode(avgMode),
    .alignLeft(alignLeft), .convBusy(convBusy), .idxSet(idxSet),
    .idxSetValue(idxSetValue), .hostRd(hostRd), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .ctrlWrValid(ctrlWrValid), .ctrlWrAddr(ctrlWrAddr),
    .ctrlWrData(ctrlWrData), .avgSel(avgSel)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmtRight(input logic [13:0] d);
    return 16'($signed(d));
  endfunction

  function automatic logic [15:0] fmtLeft(input logic [13:0] d);
    return {d, 2'b00};
  endfunction

  function automatic logic [7:0] mdlSel();
    return {mdlAvg[3], mdlAvg[2], mdlAvg[1], mdlAvg[0]};
  endfunction

  task automatic ctrlWrite(input int addr, input logic [13:0] d);
    @(negedge clk);
    ctrlWrValid = 1'b1; ctrlWrAddr = 5'(addr); ctrlWrData = d;
    @(negedge clk);
    ctrlWrValid = 1'b0;
    if (addr < 25) mdlMem[addr] = d;
  endtask

  task automatic setIdx(input int v);
    @(negedge clk);
    idxSet = 1'b1; idxSetValue = 5'(v);
    @(negedge clk);
    idxSet = 1'b0;
    if (v < 25) begin
      mdlBuf = v;
      mdlAvgIdx = v % 4;
    end
  endtask

  task automatic hostRead();
    @(negedge clk);
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    if (!cfgMode && !avgMode) mdlBuf = (mdlBuf == 24) ? 0 : mdlBuf + 1;
  endtask

  task automatic hostWrite(input logic [15:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
    if (!cfgMode && avgMode && !convBusy) begin
      mdlAvg[mdlAvgIdx] = d[1:0];
      mdlAvgIdx = (mdlAvgIdx + 1) % 4;
    end
  endtask

  task automatic testReset();
    check("R1 read data after reset", hostRdData, 16'h0);
    check("R1 avgSel after reset", {8'h0, avgSel}, 16'h0);
    hostRead();
    check("R1 entry 0 after reset", hostRdData, 16'h0);
    setIdx(24);
    hostRead();
    check("R1 entry 24 after reset", hostRdData, 16'h0);
  endtask

  task automatic testRightWalk();
    for (int e = 0; e < 25; e++) begin
      logic [13:0] v;
      v = (e == 0) ? 14'h2000 : (e == 1) ? 14'h1FFF : 14'((e * 1237 + 7900) % 16384);
      ctrlWrite(e, v);
    end
    alignLeft = 1'b0;
    setIdx(0);
    for (int e = 0; e < 25; e++) begin
      hostRead();
      check($sformatf("R2 R4 right aligned entry %0d", e), hostRdData, fmtRight(mdlMem[e]));
    end
    hostRead();
    check("R4 pointer wrapped 24 to 0", hostRdData, fmtRight(mdlMem[0]));
  endtask

  task automatic testLeft();
    alignLeft = 1'b1;
    setIdx(0);
    for (int e = 0; e < 4; e++) begin
      hostRead();
      check($sformatf("R3 left aligned entry %0d", e), hostRdData, fmtLeft(mdlMem[e]));
    end
    alignLeft = 1'b0;
  endtask

  task automatic testCtrlIgnore();
    ctrlWrite(25, 14'h1234);
    ctrlWrite(31, 14'h0ABC);
    hostWrite(16'hBEEF);
    setIdx(0);
    for (int e = 0; e < 25; e++) begin
      hostRead();
      check($sformatf("R5 entry %0d untouched", e), hostRdData, fmtRight(mdlMem[e]));
    end
  endtask

  task automatic testCollision();
    logic [13:0] oldV;
    oldV = mdlMem[7];
    setIdx(7);
    @(negedge clk);
    hostRd = 1'b1;
    ctrlWrValid = 1'b1; ctrlWrAddr = 5'd7; ctrlWrData = 14'h2ACE;
    @(negedge clk);
    hostRd = 1'b0; ctrlWrValid = 1'b0;
    mdlMem[7] = 14'h2ACE;
    mdlBuf = 8;
    check("R6 same-cycle read returns old", hostRdData, fmtRight(oldV));
    setIdx(7);
    hostRead();
    check("R6 later read returns new", hostRdData, fmtRight(14'h2ACE));
  endtask

  task automatic testAvgWrite();
    avgMode = 1'b1;
    setIdx(0);
    hostWrite(16'hFFF1);
    hostWrite(16'h0002);
    hostWrite(16'h0003);
    hostWrite(16'h0000);
    check("R7 four averaging codes", {8'h0, avgSel}, {8'h0, mdlSel()});
    check("R7 expected packing", {8'h0, avgSel}, 16'h0039);
    hostWrite(16'h0002);
    check("R7 pointer wrapped 3 to 0", {8'h0, avgSel}, 16'h003A);
  endtask

  task automatic testBusy();
    convBusy = 1'b1;
    hostWrite(16'h0001);
    check("R8 busy write ignored", {8'h0, avgSel}, {8'h0, mdlSel()});
    convBusy = 1'b0;
    hostWrite(16'h0000);
    check("R8 pointer held through busy write", {8'h0, avgSel}, 16'h0032);
  endtask

  task automatic testAvgRead();
    setIdx(1);
    hostRead();
    check("R9 averaging read reg 1", hostRdData, {14'h0, mdlAvg[1]});
    hostRead();
    check("R9 averaging read does not step", hostRdData, {14'h0, mdlAvg[1]});
    setIdx(2);
    hostRead();
    check("R9 averaging read reg 2", hostRdData, {14'h0, mdlAvg[2]});
    avgMode = 1'b0;
  endtask

  task automatic testIdxLoad();
    setIdx(5);
    setIdx(30);
    hostRead();
    check("R10 out-of-range load ignored", hostRdData, fmtRight(mdlMem[5]));
    setIdx(13);
    hostRead();
    check("R10 load entry 13", hostRdData, fmtRight(mdlMem[13]));
  endtask

  task automatic testCfg();
    logic [7:0] selBefore;
    setIdx(10);
    cfgMode = 1'b1;
    hostRead();
    check("R11 cfg-mode read is zero", hostRdData, 16'h0);
    selBefore = avgSel;
    avgMode = 1'b1;
    hostWrite(16'h0003);
    check("R11 cfg-mode write ignored", {8'h0, avgSel}, {8'h0, selBefore});
    avgMode = 1'b0;
    cfgMode = 1'b0;
    hostRead();
    check("R11 buffer pointer unmoved", hostRdData, fmtRight(mdlMem[10]));
  endtask

  initial begin
    rstN = 1'b0; cfgMode = 1'b0; avgMode = 1'b0; alignLeft = 1'b0;
    convBusy = 1'b0; idxSet = 1'b0; idxSetValue = '0; hostRd = 1'b0;
    hostWr = 1'b0; hostWrData = '0; ctrlWrValid = 1'b0; ctrlWrAddr = '0;
    ctrlWrData = '0;
    for (int e = 0; e < 25; e++) mdlMem[e] = '0;
    for (int k = 0; k < 4; k++) mdlAvg[k] = '0;
    mdlBuf = 0; mdlAvgIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRightWalk();
    testLeft();
    testCtrlIgnore();
    testCollision();
    testAvgWrite();
    testBusy();
    testAvgRead();
    testIdxLoad();
    testCfg();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule